// File: doc/BRIEF.md
# Alarm Comparator with Repeat Masks

This block watches a running BCD time of day and decides, once per second, whether an alarm has come due. Software programs four alarm fields (second, minute, hour, day of month) through a small register port. The top bit of each field is a repeat mask. The pattern of these mask bits picks the repeat rate: once a month, once a day, once an hour, once a minute, or every second.

The clock that keeps the time is outside this block. That clock supplies the current second, minute, hour and date as BCD bytes, plus a one-cycle tick in the same cycle those bytes take their new value. When the alarm fires, a sticky flag is set. A one-cycle interrupt pulse is also sent, but only when the interrupt enable bit is set. Reading the flag register clears the flag.

Top module: `alarm_match_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every alarm field, the enable register and the alarm flag return to zero, and irq_pulse and reg_rdata are zero after that edge.
- R2: A write to the alarm second field (address 0) or the alarm minute field (address 1) keeps the low 7 bits and reads them as BCD, with value = 10 × bits[6:4] + bits[3:0]. When that value is 59 or less, the whole byte is stored. Otherwise the field keeps its old content.
- R3: A write to the alarm hour field (address 2) keeps the low 6 bits and reads them as BCD. When that value is 23 or less, the whole byte is stored. Otherwise the field is unchanged.
- R4: A write to the alarm date field (address 3) keeps the low 5 bits and reads them as BCD. When that value is zero, the write is dropped. Otherwise the whole byte is stored.
- R5: A read puts its data on reg_rdata in the next cycle, and reg_rdata is zero in every cycle after a cycle with no read. The read map is as follows. Addresses 0 to 3 return the stored alarm bytes. Address 4 returns the enable register, which takes any byte on write. Address 5 returns the alarm flag in bit 6 and zeros elsewhere. Addresses 6 and 7 return zero.
- R6: Bit 7 of each alarm field is its repeat mask. When all four masks are clear, the alarm fires on a tick where all four fields match the time. The compared bits are second[6:0], minute[6:0], hour[5:0] and date[5:0].
- R7: With only the date mask set, only hour, minute and second are compared (daily repeat). With the date and hour masks set, only minute and second are compared (hourly repeat). With the date, hour and minute masks set, only second is compared (repeat every minute).
- R8: Any mask pattern other than the four named in R6 and R7 makes the alarm fire on every tick.
- R9: A firing tick raises irq_pulse for exactly the following cycle, and only if bit 7 of the enable register is set.
- R10: A firing tick sets alarm_flag in the following cycle, whatever the enable register holds. A read of address 5 clears the flag after returning the old value. When a firing tick and a flag read happen in the same cycle, the flag ends up set.
- R11: Without a tick, no firing takes place, even when the time matches the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse, time inputs are updated in this cycle |
| irq_pulse | output | 1 | One-cycle alarm interrupt |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The embedded assertions check the following on every cycle:
- a rejected field write leaves the stored byte untouched, and an accepted write stores the byte that was written;
- every interrupt pulse follows a tick while enabled;
- the flag takes the set-over-clear priority on reads;
- the read data falls back to zero after an idle cycle.

Whether the mask ladder picks the right fields to compare can only be shown by the bench's scenarios. The same holds for whether the BCD limits accept exactly the right values. These scenarios drive matching and mismatching times under each mask pattern, and the behavioural model is compared with the outputs on every clock.

// File: rtl/alarm_cmp_pkg.sv
// Shared constants, types and helper functions for the alarm comparator.
// Field index order is second, minute, hour, date; the register address of
// an alarm field equals its index.
package alarm_cmp_pkg;

    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 4;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;

    localparam int REG_ENABLE = 4;
    localparam int REG_FLAGS  = 5;

    localparam int REPEAT_BIT = 7;
    localparam int IRQ_EN_BIT = 7;
    localparam int FLAG_BIT   = 6;

    typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] tod_t;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MINUTE,
        RPT_SECOND
    } repeat_t;

    // Bits of a written byte that take part in the range check.
    function automatic logic [DATA_W-1:0] keep_mask(input int f);
        case (f)
            F_SEC, F_MIN: return 8'h7F;
            F_HOUR:       return 8'h3F;
            default:      return 8'h1F;
        endcase
    endfunction

    // Largest accepted decoded value per field.
    function automatic int max_val(input int f);
        case (f)
            F_SEC, F_MIN: return 59;
            F_HOUR:       return 23;
            default:      return 255;
        endcase
    endfunction

    // Whether a decoded value of zero is accepted.
    function automatic bit zero_ok(input int f);
        return (f != F_DATE);
    endfunction

    // Bits of each field that are compared against the running time.
    function automatic logic [DATA_W-1:0] cmp_mask(input int f);
        case (f)
            F_SEC, F_MIN: return 8'h7F;
            default:      return 8'h3F;
        endcase
    endfunction

    // Two-digit BCD to binary; the tens digit is taken as given.
    function automatic logic [DATA_W-1:0] bcd_to_bin(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] tens;
        logic [DATA_W-1:0] ones;
        tens = {4'd0, v[7:4]};
        ones = {4'd0, v[3:0]};
        return tens * 8'd10 + ones;
    endfunction

endpackage

// File: rtl/alarm_field_reg.sv
// One alarm field register with write validation.
// Assumes an 8-bit BCD byte; KEEP selects the bits decoded for the range
// check, the whole byte (mask bit included) is stored when accepted.
module alarm_field_reg
    import alarm_cmp_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEEP = 8'h7F,
    parameter int                MAXV = 59,
    parameter bit                ZOK  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] decoded;
    logic              accept;

    // Decode the kept bits and test them against the field limits.
    always_comb begin
        decoded = bcd_to_bin(wdata & KEEP);
        accept  = (int'(decoded) <= MAXV) && (ZOK || (decoded != '0));
    end

    // Store an accepted write; ignore a rejected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en && accept) begin
            value <= wdata;
        end
    end

    // R2 R3 R4: a rejected write keeps the old content.
    a_r2_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(value));

    // R2 R3 R4: an accepted write stores the full byte.
    a_r2_accept_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && accept) |=> (value == $past(wdata)));

endmodule

// File: rtl/alarm_regfile.sv
// Alarm field registers (one per field, built by generate) plus the
// interrupt enable register. Field address equals field index.
module alarm_regfile
    import alarm_cmp_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tod_t              alarm_f,
    output logic [DATA_W-1:0] enable_r
);

    genvar f;
    generate
        for (f = 0; f < NUM_FIELDS; f++) begin : g_field
            logic sel;
            assign sel = wr && (addr == ADDR_W'(f));
            alarm_field_reg #(
                .KEEP (keep_mask(f)),
                .MAXV (max_val(f)),
                .ZOK  (zero_ok(f))
            ) u_field (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (sel),
                .wdata (wdata),
                .value (alarm_f[f])
            );
        end
    endgenerate

    // Enable register accepts any byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_r <= '0;
        end else if (wr && (addr == ADDR_W'(REG_ENABLE))) begin
            enable_r <= wdata;
        end
    end

endmodule

// File: rtl/alarm_mode_decode.sv
// Turns the four repeat-mask bits into a repeat mode and the set of fields
// that must match. Assumes rpt[f] is bit 7 of alarm field f.
module alarm_mode_decode
    import alarm_cmp_pkg::*;
(
    input  logic [NUM_FIELDS-1:0] rpt,
    output logic [NUM_FIELDS-1:0] need
);

    repeat_t mode;

    // Pick the repeat mode from the mask ladder.
    always_comb begin
        case ({rpt[F_DATE], rpt[F_HOUR], rpt[F_MIN], rpt[F_SEC]})
            4'b0000: mode = RPT_MONTH;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MINUTE;
            default: mode = RPT_SECOND;
        endcase
    end

    // Fields taking part in the comparison for each mode.
    always_comb begin
        need = '0;
        case (mode)
            RPT_MONTH:  need = 4'b1111;
            RPT_DAY:    need = 4'b0111;
            RPT_HOUR:   need = 4'b0011;
            RPT_MINUTE: need = 4'b0001;
            default:    need = 4'b0000;
        endcase
    end

endmodule

// File: rtl/alarm_compare.sv
// Per-field equality of alarm against current time, then a firing decision
// on the tick. Assumes time inputs are already updated when sec_tick is high.
module alarm_compare
    import alarm_cmp_pkg::*;
(
    input  tod_t                  alarm_f,
    input  tod_t                  now_tod,
    input  logic [NUM_FIELDS-1:0] need,
    input  logic                  sec_tick,
    output logic                  fire
);

    logic [NUM_FIELDS-1:0] eq;

    genvar f;
    generate
        for (f = 0; f < NUM_FIELDS; f++) begin : g_eq
            assign eq[f] = (((alarm_f[f] ^ now_tod[f]) & cmp_mask(f)) == '0);
        end
    endgenerate

    // Fire when every required field matches on a tick.
    assign fire = sec_tick && ((eq | ~need) == '1);

endmodule

// File: rtl/alarm_event.sv
// Produces the gated interrupt pulse and the sticky flag from a firing
// event. Set takes priority over a read-clear in the same cycle.
module alarm_event (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic irq_en,
    input  logic flag_clr,
    output logic irq_pulse,
    output logic alarm_flag
);

    // One-cycle pulse, gated by the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= fire && irq_en;
        end
    end

    // Sticky flag: set on firing, cleared by a flag read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
        end else if (fire) begin
            alarm_flag <= 1'b1;
        end else if (flag_clr) begin
            alarm_flag <= 1'b0;
        end
    end

    // R9: a pulse needs a firing event while enabled in the previous cycle.
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(fire) && $past(irq_en)));

    // R10: firing wins over a simultaneous clear.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fire)) |-> alarm_flag);

    // R10: a clear without firing drops the flag.
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_clr) && !$past(fire)) |-> !alarm_flag);

endmodule

// File: rtl/alarm_match_unit.sv
// Top of the alarm comparator: register port, mask-ladder decode, field
// compare and event generation. Read data is registered and is zero after
// a cycle without a read. Assumes BCD time inputs from an external clock.
module alarm_match_unit
    import alarm_cmp_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_date,
    input  logic              sec_tick,
    output logic              irq_pulse,
    output logic              alarm_flag
);

    tod_t                  alarm_f;
    tod_t                  now_tod;
    logic [DATA_W-1:0]     enable_r;
    logic [NUM_FIELDS-1:0] rpt;
    logic [NUM_FIELDS-1:0] need;
    logic                  fire;
    logic                  flag_clr;
    logic [DATA_W-1:0]     rd_mux;

    assign now_tod  = {cur_date, cur_hour, cur_min, cur_sec};
    assign flag_clr = reg_rd && (reg_addr == ADDR_W'(REG_FLAGS));

    genvar f;
    generate
        for (f = 0; f < NUM_FIELDS; f++) begin : g_rpt
            assign rpt[f] = alarm_f[f][REPEAT_BIT];
        end
    endgenerate

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .alarm_f  (alarm_f),
        .enable_r (enable_r)
    );

    alarm_mode_decode u_mode (
        .rpt  (rpt),
        .need (need)
    );

    alarm_compare u_cmp (
        .alarm_f  (alarm_f),
        .now_tod  (now_tod),
        .need     (need),
        .sec_tick (sec_tick),
        .fire     (fire)
    );

    alarm_event u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .irq_en     (enable_r[IRQ_EN_BIT]),
        .flag_clr   (flag_clr),
        .irq_pulse  (irq_pulse),
        .alarm_flag (alarm_flag)
    );

    // Select the register addressed by a read.
    always_comb begin
        rd_mux = '0;
        if (int'(reg_addr) < NUM_FIELDS) begin
            rd_mux = alarm_f[reg_addr[1:0]];
        end else if (reg_addr == ADDR_W'(REG_ENABLE)) begin
            rd_mux = enable_r;
        end else if (reg_addr == ADDR_W'(REG_FLAGS)) begin
            rd_mux[FLAG_BIT] = alarm_flag;
        end
    end

    // Register the read data; zero when no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= reg_rd ? rd_mux : '0;
        end
    end

    // R11: the flag only rises after a tick.
    a_r11_no_tick_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(alarm_flag)) |-> $past(sec_tick));

    // R9: a pulse always follows a tick.
    a_r9_pulse_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(sec_tick));

    // R5: read data is zero after a cycle without a read.
    a_r5_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_rd)) |-> (reg_rdata == '0));

endmodule

// File: tb/alarm_match_unit_tb_top.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against every output on each falling edge.
module alarm_match_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] cur_sec, cur_min, cur_hour, cur_date;
    logic       sec_tick;
    logic       irq_pulse, alarm_flag;

    int    checks   = 0;
    int    failures = 0;
    bit    finished = 0;
    string tag      = "R1";

    logic [7:0] m_al [4];
    logic [7:0] m_en;
    logic       m_flag, m_irq;
    logic [7:0] m_rdata;

    always #5 clk = ~clk;

    alarm_match_unit #(.ADDR_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .sec_tick(sec_tick),
        .irq_pulse(irq_pulse), .alarm_flag(alarm_flag)
    );

    function automatic int bcd(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        logic       fire;
        logic [3:0] msk;
        bit         ms, mm, mh, md;
        int         v;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_al[i] = 8'h00;
            m_en = 0; m_flag = 0; m_irq = 0; m_rdata = 0;
        end else begin
            ms = (m_al[0][6:0] == cur_sec[6:0]);
            mm = (m_al[1][6:0] == cur_min[6:0]);
            mh = (m_al[2][5:0] == cur_hour[5:0]);
            md = (m_al[3][5:0] == cur_date[5:0]);
            msk = {m_al[3][7], m_al[2][7], m_al[1][7], m_al[0][7]};
            if (msk == 4'b0000)      fire = ms && mm && mh && md;
            else if (msk == 4'b1000) fire = ms && mm && mh;
            else if (msk == 4'b1100) fire = ms && mm;
            else if (msk == 4'b1110) fire = ms;
            else                     fire = 1'b1;
            fire = fire && sec_tick;

            m_rdata = 8'h00;
            if (reg_rd) begin
                if (reg_addr < 4)       m_rdata = m_al[reg_addr];
                else if (reg_addr == 4) m_rdata = m_en;
                else if (reg_addr == 5) m_rdata = {1'b0, m_flag, 6'b0};
            end
            if (reg_rd && reg_addr == 5) m_flag = 1'b0;
            if (fire) m_flag = 1'b1;
            m_irq = fire && m_en[7];

            if (reg_wr) begin
                case (reg_addr)
                    3'd0, 3'd1: begin
                        v = bcd(reg_wdata & 8'h7F);
                        if (v <= 59) m_al[reg_addr] = reg_wdata;
                    end
                    3'd2: begin
                        v = bcd(reg_wdata & 8'h3F);
                        if (v <= 23) m_al[2] = reg_wdata;
                    end
                    3'd3: begin
                        v = bcd(reg_wdata & 8'h1F);
                        if (v != 0) m_al[3] = reg_wdata;
                    end
                    3'd4: m_en = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare all outputs on every falling edge.
    always @(negedge clk) begin
        if (!finished && rst_n !== 1'bx) begin
            chk("irq_pulse",  {7'd0, irq_pulse},  {7'd0, m_irq});
            chk("alarm_flag", {7'd0, alarm_flag}, {7'd0, m_flag});
            chk("reg_rdata",  reg_rdata,          m_rdata);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic tick(input logic [7:0] d, input logic [7:0] h,
                        input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        cur_date = d; cur_hour = h; cur_min = m; cur_sec = s; sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
        @(negedge clk);
    endtask

    task automatic set_alarm(input logic [7:0] d, input logic [7:0] h,
                             input logic [7:0] m, input logic [7:0] s);
        wr(3'd3, d); wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
        rd(3'd5);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL %s watchdog expired", tag);
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        cur_sec = 0; cur_min = 0; cur_hour = 0; cur_date = 8'h01; sec_tick = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        tag = "R1";
        for (int a = 0; a < 8; a++) rd(3'(a));

        tag = "R2";
        wr(3'd0, 8'h59); rd(3'd0);
        wr(3'd0, 8'h60); rd(3'd0);
        wr(3'd0, 8'hD9); rd(3'd0);
        wr(3'd1, 8'h5A); rd(3'd1);
        wr(3'd1, 8'h00); rd(3'd1);
        wr(3'd1, 8'h7F); rd(3'd1);

        tag = "R3";
        wr(3'd2, 8'h23); rd(3'd2);
        wr(3'd2, 8'h24); rd(3'd2);
        wr(3'd2, 8'hA3); rd(3'd2);
        wr(3'd2, 8'h40); rd(3'd2);

        tag = "R4";
        wr(3'd3, 8'h15); rd(3'd3);
        wr(3'd3, 8'h00); rd(3'd3);
        wr(3'd3, 8'h80); rd(3'd3);
        wr(3'd3, 8'h31); rd(3'd3);

        tag = "R5";
        wr(3'd4, 8'h5A); rd(3'd4);
        wr(3'd4, 8'h80); rd(3'd4);
        rd(3'd6); rd(3'd7); rd(3'd5);

        tag = "R6";
        set_alarm(8'h15, 8'h10, 8'h20, 8'h30);
        tick(8'h15, 8'h10, 8'h20, 8'h30); rd(3'd5);
        tick(8'h16, 8'h10, 8'h20, 8'h30);
        tick(8'h15, 8'h11, 8'h20, 8'h30);
        tick(8'h15, 8'h10, 8'h21, 8'h30);
        tick(8'h15, 8'h10, 8'h20, 8'h31);
        rd(3'd5);

        tag = "R7";
        set_alarm(8'h95, 8'h10, 8'h20, 8'h30);
        tick(8'h02, 8'h10, 8'h20, 8'h30); rd(3'd5);
        tick(8'h02, 8'h11, 8'h20, 8'h30); rd(3'd5);
        set_alarm(8'h95, 8'h90, 8'h20, 8'h30);
        tick(8'h02, 8'h07, 8'h20, 8'h30); rd(3'd5);
        tick(8'h02, 8'h07, 8'h21, 8'h30); rd(3'd5);
        set_alarm(8'h95, 8'h90, 8'hA0, 8'h30);
        tick(8'h02, 8'h07, 8'h44, 8'h30); rd(3'd5);
        tick(8'h02, 8'h07, 8'h44, 8'h31); rd(3'd5);

        tag = "R8";
        set_alarm(8'h15, 8'h10, 8'h20, 8'hB0);
        tick(8'h01, 8'h02, 8'h03, 8'h04); rd(3'd5);
        set_alarm(8'h15, 8'h90, 8'h20, 8'h30);
        tick(8'h01, 8'h02, 8'h03, 8'h04); rd(3'd5);
        set_alarm(8'h95, 8'h90, 8'hA0, 8'hB0);
        tick(8'h01, 8'h02, 8'h03, 8'h04);
        tick(8'h01, 8'h02, 8'h03, 8'h05); rd(3'd5);

        tag = "R9";
        wr(3'd4, 8'h7F);
        tick(8'h01, 8'h02, 8'h03, 8'h06); rd(3'd5);
        wr(3'd4, 8'h80);
        tick(8'h01, 8'h02, 8'h03, 8'h07);

        tag = "R10";
        @(negedge clk);
        reg_rd = 1; reg_addr = 3'd5; sec_tick = 1;
        @(negedge clk);
        reg_rd = 0; sec_tick = 0;
        rd(3'd5); rd(3'd5);

        tag = "R11";
        set_alarm(8'h15, 8'h10, 8'h20, 8'h30);
        @(negedge clk);
        cur_date = 8'h15; cur_hour = 8'h10; cur_min = 8'h20; cur_sec = 8'h30;
        repeat (5) @(negedge clk);
        rd(3'd5);
        tick(8'h15, 8'h10, 8'h20, 8'h30); rd(3'd5);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule